// File: doc/BRIEF.md
# Infrared SIR Transmit Pulse Encoder

This block sits between a UART transmitter and an infrared LED driver. It turns the UART's serial output into SIR-style return-to-zero light pulses. A logic '0' bit becomes one short high pulse near the start of the bit period. A logic '1' bit leaves the LED dark. The UART supplies two timing inputs: a one-cycle strobe at the start of every bit period, and a 16x oversampling tick.

Two pulse widths are offered. In proportional mode the pulse lasts three oversampling ticks, which is 3/16 of the current bit time. In fixed mode the pulse lasts 3/16 of a 115,200 bit/s bit time whatever baud rate is in use. At the default 18.432 MHz system clock that is 30 cycles, about 1.6 µs, and it saves LED power at slow rates. Encoding runs only while both the UART enable and the SIR enable are set. Otherwise the LED output stays low and the raw serial line is presented on a separate pass-through output.

Top module: `sir_tx_encoder`

## Requirements
- R1: While encoding is inactive (uartEn or sirEn low, as registered), irOut stays low and txPass equals txData in the same cycle.
- R2: Setting sirEn with uartEn low has no effect: no pulse is produced for '0' bits and txPass keeps following txData.
- R3: Reset clears the registered controls. After reset the block is in proportional mode with encoding off, irOut is low and txPass follows txData.
- R4: With encoding active, a bitStart strobe with txData = 0 makes irOut go high on the first clock after the strobe cycle.
- R5: A bit with txData = 1 produces no pulse: irOut stays low for the whole bit period.
- R6: In proportional mode (mode captured as 0) the pulse stays high until the clock edge that samples the third tick16 after the strobe cycle. This is 3 tick periods, or 3/16 of the bit time.
- R7: In fixed mode (mode captured as 1) the pulse lasts exactly FIXED_CYC clock cycles (30 by default), whatever the tick16 rate is.
- R8: A pulse never runs past its own bit: a bitStart strobe ends it at that edge, and irOut is low on the next cycle unless that new bit is a '0'.
- R9: The width mode is captured when a pulse starts. A change of fixedMode during a pulse does not alter that pulse and applies from the next bit.
- R10: Control inputs take effect one clock after they are applied. While encoding is active, txPass is held at 1.
- R11: If encoding is turned off in the middle of a pulse, irOut goes low two cycles after the control input falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (18.432 MHz nominal) |
| rstN | input | 1 | Active-low synchronous reset |
| uartEn | input | 1 | UART enable; encoding requires it |
| sirEn | input | 1 | SIR encoding enable |
| fixedMode | input | 1 | 1 = fixed 30-cycle pulse, 0 = 3/16 of bit time |
| bitStart | input | 1 | One-cycle strobe marking the first cycle of each bit |
| tick16 | input | 1 | 16x oversampling tick |
| txData | input | 1 | UART serial transmit data |
| irOut | output | 1 | Active-high infrared LED drive |
| txPass | output | 1 | Raw serial data when encoding is off, 1 when encoding is on |

## Verification
The critical overlap is a pulse that is still running when the next bitStart arrives. This happens in fixed mode at the fastest tick rate, where the 30-cycle pulse is longer than the 16-cycle bit. In that cycle, truncation and the start of a new pulse both want to change the pulse register. The bench runs back-to-back bits this way and checks every cycle against expected windows computed from the bit index. The expected sequence is: the old pulse is still high on the strobe cycle, then either a fresh pulse follows or the line goes low on the very next cycle. A second overlap, a mode or enable change landing inside a pulse, is driven at chosen cycle offsets. The resulting widths are then compared with the old-mode and two-cycle-shutoff windows.

// File: rtl/sir_tx_pkg.sv
package sir_tx_pkg;

  // Command strobes from the control half to the pulse datapath
  typedef struct packed {
    logic start;     // begin a pulse on this edge
    logic clear;     // end any pulse on this edge (start wins)
    logic useFixed;  // width mode to latch with start
  } pulseCmd_t;

endpackage

// File: rtl/sir_tx_ctrl.sv
module sir_tx_ctrl
  import sir_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      uartEn,
  input  logic      sirEn,
  input  logic      fixedMode,
  input  logic      bitStart,
  input  logic      txData,
  output pulseCmd_t cmd,
  output logic      sirActive,
  output logic      txPass
);

  logic cfgUart;
  logic cfgSir;
  logic cfgFixed;

  // Registered controls; cleared by reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgUart  <= 1'b0;
      cfgSir   <= 1'b0;
      cfgFixed <= 1'b0;
    end else begin
      cfgUart  <= uartEn;
      cfgSir   <= sirEn;
      cfgFixed <= fixedMode;
    end
  end

  assign sirActive = cfgUart & cfgSir;

  always_comb begin
    cmd.start    = sirActive & bitStart & ~txData;
    cmd.clear    = ~sirActive | bitStart;
    cmd.useFixed = cfgFixed;
  end

  assign txPass = sirActive ? 1'b1 : txData;

  AST_PASS_MUTED: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(uartEn) && $past(sirEn)) |-> txPass); // R10

endmodule

// File: rtl/sir_tx_pulse.sv
module sir_tx_pulse
  import sir_tx_pkg::*;
#(
  parameter int FIXED_CYC  = 30,
  parameter int TICK_COUNT = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  pulseCmd_t cmd,
  input  logic      tick16,
  output logic      irOut
);

  localparam int CW = $clog2(FIXED_CYC + 1);
  localparam int TW = $clog2(TICK_COUNT + 1);
  localparam int HW = CW + 1;

  logic          pulseOn;
  logic          pulseFixed;
  logic [TW-1:0] tickCnt;
  logic [CW-1:0] cycCnt;
  logic [HW-1:0] hiCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pulseOn    <= 1'b0;
      pulseFixed <= 1'b0;
      tickCnt    <= '0;
      cycCnt     <= '0;
    end else if (cmd.start) begin
      pulseOn    <= 1'b1;
      pulseFixed <= cmd.useFixed;
      tickCnt    <= '0;
      cycCnt     <= CW'(FIXED_CYC - 1);
    end else if (cmd.clear) begin
      pulseOn    <= 1'b0;
    end else if (pulseOn) begin
      if (pulseFixed) begin
        if (cycCnt == '0) pulseOn <= 1'b0;
        else              cycCnt  <= cycCnt - 1'b1;
      end else if (tick16) begin
        if (tickCnt == TW'(TICK_COUNT - 1)) pulseOn <= 1'b0;
        else                                tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  assign irOut = pulseOn;

  // Length of the current high run, saturating
  always_ff @(posedge clk) begin
    if (!rstN)                            hiCnt <= '0;
    else if (cmd.start)                   hiCnt <= HW'(1);
    else if (pulseOn && hiCnt != '1)      hiCnt <= hiCnt + 1'b1;
    else if (!pulseOn)                    hiCnt <= '0;
  end

  AST_FIXED_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pulseOn) && $past(pulseFixed) && !$past(cmd.clear)) |-> ($past(hiCnt) == HW'(FIXED_CYC))); // R7

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (pulseOn && !cmd.start) |=> (pulseFixed == $past(pulseFixed))); // R9

endmodule

// File: rtl/sir_tx_encoder.sv
module sir_tx_encoder
  import sir_tx_pkg::*;
#(
  parameter int REF_CLK_HZ = 18_432_000,
  parameter int REF_BAUD   = 115_200,
  parameter int PULSE_NUM  = 3,
  parameter int PULSE_DEN  = 16
) (
  input  logic clk,
  input  logic rstN,
  input  logic uartEn,
  input  logic sirEn,
  input  logic fixedMode,
  input  logic bitStart,
  input  logic tick16,
  input  logic txData,
  output logic irOut,
  output logic txPass
);

  localparam int REF_BIT_CYC = REF_CLK_HZ / REF_BAUD;
  localparam int FIXED_CYC   = REF_BIT_CYC * PULSE_NUM / PULSE_DEN;

  pulseCmd_t cmd;
  logic      sirActive;

  sir_tx_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .uartEn    (uartEn),
    .sirEn     (sirEn),
    .fixedMode (fixedMode),
    .bitStart  (bitStart),
    .txData    (txData),
    .cmd       (cmd),
    .sirActive (sirActive),
    .txPass    (txPass)
  );

  sir_tx_pulse #(
    .FIXED_CYC  (FIXED_CYC),
    .TICK_COUNT (PULSE_NUM)
  ) uPulse (
    .clk    (clk),
    .rstN   (rstN),
    .cmd    (cmd),
    .tick16 (tick16),
    .irOut  (irOut)
  );

  AST_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rstN)
    !(uartEn && sirEn) |-> ##2 !irOut); // R2

  AST_ZERO_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irOut) |-> ($past(bitStart) && !$past(txData))); // R5

  AST_NO_STRETCH: assert property (@(posedge clk) disable iff (!rstN)
    (bitStart && txData) |=> !irOut); // R8

endmodule

// File: tb/tb_sir_tx_encoder.sv
`timescale 1ns/1ps
module tb_sir_tx_encoder;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic uartEn = 1'b0, sirEn = 1'b0, fixedMode = 1'b0;
  logic bitStart = 1'b0, tick16 = 1'b0, txData = 1'b1;
  logic irOut, txPass;

  always #4 clk = ~clk;

  sir_tx_encoder dut (
    .clk(clk), .rstN(rstN), .uartEn(uartEn), .sirEn(sirEn),
    .fixedMode(fixedMode), .bitStart(bitStart), .tick16(tick16),
    .txData(txData), .irOut(irOut), .txPass(txPass)
  );

  localparam int FIXED_W = 30;

  int total = 0;
  int bad = 0;
  logic  irQ[$];
  logic  passQ[$];
  string tagQ[$];

  logic nextSir = 1'b0, nextUart = 1'b0, nextMode = 1'b0;
  logic prevActive = 1'b0, prevFixed = 1'b0;
  logic carry = 1'b0;

  task automatic driveCycle(input logic bs, input logic tk, input logic td,
                            input logic er, input string tag);
    @(posedge clk); #1;
    bitStart = bs; tick16 = tk; txData = td;
    sirEn = nextSir; uartEn = nextUart; fixedMode = nextMode;
    irQ.push_back(er);
    passQ.push_back(prevActive ? 1'b1 : td);
    tagQ.push_back(tag);
    prevActive = nextSir && nextUart;
    prevFixed  = nextMode;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      driveCycle(1'b0, 1'b0, 1'b1, (i == 0) ? carry : 1'b0, tag);
      carry = 1'b0;
    end
  endtask

  // kind: 0 none, 1 flip mode at cycle chgAt, 2 drop sirEn at cycle chgAt
  task automatic sendBit(input logic bitVal, input int div, input int chgAt,
                         input int kind, input string tag);
    logic zero;
    int w, per;
    logic ex;
    zero = !bitVal && prevActive;
    w    = prevFixed ? FIXED_W : 3 * div;
    per  = 16 * div;
    for (int j = 0; j < per; j++) begin
      if (j == chgAt && kind == 1) nextMode = !nextMode;
      if (j == chgAt && kind == 2) nextSir = 1'b0;
      if (j == 0) ex = carry;
      else ex = zero && (j <= w) && !(kind == 2 && j > chgAt + 1);
      driveCycle(j == 0, (j % div) == 0, bitVal, ex, tag);
    end
    carry = zero && (w >= per) && (kind != 2);
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (irQ.size() > 0) begin
        logic eIr, ePass;
        string t;
        eIr = irQ.pop_front(); ePass = passQ.pop_front(); t = tagQ.pop_front();
        total++;
        if (irOut !== eIr) begin
          bad++;
          $display("FAIL %s irOut actual=%b expected=%b at %0t", t, irOut, eIr, $time);
        end
        total++;
        if (txPass !== ePass) begin
          bad++;
          $display("FAIL %s txPass actual=%b expected=%b at %0t", t, txPass, ePass, $time);
        end
      end
    end
  end

  initial begin
    #(8 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R3: after reset, controls cleared; pass-through, no pulse
    driveCycle(1'b1, 1'b1, 1'b0, 1'b0, "R3");
    driveCycle(1'b0, 1'b0, 1'b1, 1'b0, "R3");
    driveCycle(1'b0, 1'b0, 1'b0, 1'b0, "R3");
    // R1: encoding off
    sendBit(1'b0, 2, -1, 0, "R1");
    sendBit(1'b1, 2, -1, 0, "R1");
    // R2: SIR enable without UART enable
    nextSir = 1'b1;
    idle(2, "R2");
    sendBit(1'b0, 2, -1, 0, "R2");
    // R10: enable applies one clock later, txPass held high
    nextUart = 1'b1;
    driveCycle(1'b0, 1'b0, 1'b0, 1'b0, "R10");
    driveCycle(1'b0, 1'b0, 1'b0, 1'b0, "R10");
    idle(1, "R10");
    // R5, R4, R6: proportional mode
    sendBit(1'b1, 2, -1, 0, "R5");
    sendBit(1'b0, 2, -1, 0, "R4");
    sendBit(1'b0, 1, -1, 0, "R6");
    sendBit(1'b0, 4, -1, 0, "R6");
    idle(3, "R6");
    // R7: fixed mode independent of tick rate
    nextMode = 1'b1;
    idle(2, "R7");
    sendBit(1'b0, 2, -1, 0, "R7");
    sendBit(1'b0, 4, -1, 0, "R7");
    sendBit(1'b1, 4, -1, 0, "R7");
    // R8: fixed pulse longer than a bit, truncated by the next strobe
    sendBit(1'b0, 1, -1, 0, "R8");
    sendBit(1'b1, 1, -1, 0, "R8");
    sendBit(1'b0, 1, -1, 0, "R8");
    sendBit(1'b0, 1, -1, 0, "R8");
    sendBit(1'b1, 4, -1, 0, "R8");
    // R9: mode change in the middle of a pulse
    sendBit(1'b0, 4, 5, 1, "R9");
    idle(2, "R9");
    sendBit(1'b0, 4, -1, 0, "R9");
    sendBit(1'b0, 4, 3, 1, "R9");
    idle(2, "R9");
    // R11: encoding turned off mid-pulse
    sendBit(1'b0, 4, 10, 2, "R11");
    idle(3, "R11");
    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule